// File: doc/BRIEF.md
# Disk Controller Soft-Switch Decoder

This block sits on a peripheral bus and turns bus accesses inside a 16-location I/O window into control latch updates for a floppy drive controller. The address of an access is enough to change the state. The window's nibble is split into a latch selector and a value bit, and the data bus is not used for this. The latches drive the four stepper phase coils, the spindle motor, the choice between two drives, and a pair of mode bits. The mode bits pick between reading the data latch, sensing the write-protect switch, shifting, and loading a byte to be written.

Each controller responds at a fixed base address plus sixteen times its slot number. Slot numbers 1 to 7 are valid. Slot 0 never responds. During an access the block also returns, on the read data bus, either the sequencer's data latch or the write-protect status, depending on the mode that held before the access. The disk read/write sequencer is a separate block. This one only supplies it with mode and write data, and takes its data latch back.

Top module: `dsk_sw_decoder`

## Requirements
- R1: An access hits when `bus_sel` is high, `slot_i` is non-zero, and `bus_addr[15:4]` equals `BASE[15:4] + slot_i`. An access that does not hit leaves every latch and `wr_byte_o` unchanged.
- R2: A hit with offset `bus_addr[3:0]` in 0..7 sets stepper phase `bus_addr[2:1]` to the value of `bus_addr[0]`. Offset 2n turns phase n off and offset 2n+1 turns it on. The other phases are unchanged.
- R3: Offset 8 clears the motor latch and offset 9 sets it.
- R4: Offset A selects drive 1 (`drive2_o`=0) and offset B selects drive 2 (`drive2_o`=1). `drv_en_o[0]` equals motor AND NOT drive2, and `drv_en_o[1]` equals motor AND drive2, so at most one drive is powered.
- R5: Offsets C and D clear and set `q6_o`. Offsets E and F clear and set `q7_o`.
- R6: During a hit, if Q7=0 and Q6=0 held before the access (read mode), `bus_rdata` equals `rd_latch_i`.
- R7: During a hit, if Q7=0 and Q6=1 held before the access (sense mode), `bus_rdata` equals `{wp_i, 7'b0}`.
- R8: A hit with `bus_we`=1 that leaves Q7=1 and Q6=1 after its own latch update loads `bus_wdata` into `wr_byte_o` on that clock edge. Any other access leaves `wr_byte_o` unchanged.
- R9: Synchronous active-high reset clears all phases, the motor, the drive select, Q6, Q7 and `wr_byte_o`.
- R10: `bus_rdata` is zero when there is no hit, or when Q7=1 held before the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_i | input | 3 | Slot number of this controller (0 disables it) |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_addr | input | 16 | Bus address |
| bus_we | input | 1 | Access is a write |
| bus_wdata | input | 8 | Write data from the bus |
| bus_rdata | output | 8 | Read data returned during a hit |
| rd_latch_i | input | 8 | Data latch byte from the sequencer |
| wp_i | input | 1 | Write-protect switch, high when protected |
| phase_o | output | 4 | Stepper phase enables |
| motor_o | output | 1 | Spindle motor latch |
| drive2_o | output | 1 | Drive select, 1 = drive 2 |
| drv_en_o | output | 2 | Per-drive motor power enable |
| q6_o | output | 1 | Mode latch Q6 |
| q7_o | output | 1 | Mode latch Q7 |
| wr_byte_o | output | 8 | Write data register for the sequencer |

## Verification
The bench builds the block with its default base of 16'hC080 and an 8-bit data path. It drives the slot input at run time, so windows for slot 6, slot 1 and the rejected slot 0 are all reached with one elaboration. Stepping through the phase offsets walks the coil pattern up and down the way a head seek would. The motor, drive and mode offsets reach every combination of the two mode bits, which covers the read, sense and write-load paths.

// File: rtl/dsk_sw_pkg.sv
package dsk_sw_pkg;

    localparam int NUM_PHASES = 4;
    localparam int OFF_W      = 4;

    typedef struct packed {
        logic [NUM_PHASES-1:0] phase;
        logic                  motor;
        logic                  drive2;
        logic                  q6;
        logic                  q7;
    } sw_state_t;

    typedef enum logic [1:0] {
        MODE_READ  = 2'b00,
        MODE_SENSE = 2'b01,
        MODE_SHIFT = 2'b10,
        MODE_LOAD  = 2'b11
    } io_mode_t;

    localparam sw_state_t SW_RESET = '0;

    function automatic io_mode_t mode_of(input sw_state_t s);
        return io_mode_t'({s.q7, s.q6});
    endfunction

    // Bits 3..1 of the offset pick a latch, bit 0 is its new value.
    function automatic sw_state_t apply_switch(input sw_state_t s,
                                               input logic [OFF_W-1:0] off);
        sw_state_t n;
        n = s;
        unique case (off[3:1])
            3'd0, 3'd1, 3'd2, 3'd3: n.phase[off[2:1]] = off[0];
            3'd4:                   n.motor           = off[0];
            3'd5:                   n.drive2          = off[0];
            3'd6:                   n.q6              = off[0];
            default:                n.q7              = off[0];
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dsk_sw_window.sv
module dsk_sw_window #(
    parameter int                ADDR_W = 16,
    parameter int                SLOT_W = 3,
    parameter logic [ADDR_W-1:0] BASE   = 16'hC080
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              hit,
    output logic [3:0]        off
);
    localparam int HI_W = ADDR_W - 4;
    localparam logic [HI_W-1:0] BASE_HI = BASE[ADDR_W-1:4];

    logic [HI_W-1:0] win_hi;

    always_comb begin
        win_hi = BASE_HI + HI_W'(slot_i);
        hit    = bus_sel && (slot_i != '0) && (bus_addr[ADDR_W-1:4] == win_hi);
        off    = bus_addr[3:0];
    end
endmodule

// File: rtl/dsk_sw_latches.sv
module dsk_sw_latches
    import dsk_sw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [3:0]        off,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output sw_state_t         state,
    output logic [DATA_W-1:0] wr_byte
);
    sw_state_t nxt;

    always_comb nxt = apply_switch(state, off);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SW_RESET;
            wr_byte <= '0;
        end else if (hit) begin
            state <= nxt;
            if (we && mode_of(nxt) == MODE_LOAD)
                wr_byte <= wdata;
        end
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |=> ($stable(state) && $stable(wr_byte)));

    // R2
    single_latch_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> ($countones(state ^ $past(state)) <= 1));

    // R8
    load_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit && we) |=> $stable(wr_byte));
endmodule

// File: rtl/dsk_sw_rdmux.sv
module dsk_sw_rdmux
    import dsk_sw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  sw_state_t         state,
    input  logic              hit,
    input  logic [DATA_W-1:0] rd_latch,
    input  logic              wp,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (hit) begin
            case (mode_of(state))
                MODE_READ:  rdata = rd_latch;
                MODE_SENSE: rdata = {wp, {(DATA_W-1){1'b0}}};
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dsk_sw_decoder.sv
module dsk_sw_decoder
    import dsk_sw_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter int                SLOT_W = 3,
    parameter int                DATA_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 16'hC080
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SLOT_W-1:0]     slot_i,
    input  logic                  bus_sel,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [DATA_W-1:0]     rd_latch_i,
    input  logic                  wp_i,
    output logic [NUM_PHASES-1:0] phase_o,
    output logic                  motor_o,
    output logic                  drive2_o,
    output logic [1:0]            drv_en_o,
    output logic                  q6_o,
    output logic                  q7_o,
    output logic [DATA_W-1:0]     wr_byte_o
);
    logic      hit;
    logic [3:0] off;
    sw_state_t state;

    dsk_sw_window #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .BASE(BASE)) u_window (
        .bus_sel (bus_sel),
        .bus_addr(bus_addr),
        .slot_i  (slot_i),
        .hit     (hit),
        .off     (off)
    );

    dsk_sw_latches #(.DATA_W(DATA_W)) u_latches (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .off    (off),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .state  (state),
        .wr_byte(wr_byte_o)
    );

    dsk_sw_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .state   (state),
        .hit     (hit),
        .rd_latch(rd_latch_i),
        .wp      (wp_i),
        .rdata   (bus_rdata)
    );

    always_comb begin
        phase_o  = state.phase;
        motor_o  = state.motor;
        drive2_o = state.drive2;
        q6_o     = state.q6;
        q7_o     = state.q7;
        drv_en_o = {state.motor & state.drive2, state.motor & ~state.drive2};
    end

    // R4
    drive_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_en_o) && (motor_o || drv_en_o == 2'b00));

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_sel || q7_o) |-> (bus_rdata == '0));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (phase_o == '0 && !motor_o && !drive2_o && !q6_o && !q7_o));
endmodule

// File: tb/dsk_sw_decoder_tb.sv
module dsk_sw_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic       clk = 0;
    logic       rst;
    logic [2:0] slot_i;
    logic       bus_sel;
    logic [15:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [7:0] rd_latch_i;
    logic       wp_i;
    logic [3:0] phase_o;
    logic       motor_o, drive2_o, q6_o, q7_o;
    logic [1:0] drv_en_o;
    logic [7:0] wr_byte_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsk_sw_decoder u_dut (
        .clk(clk), .rst(rst), .slot_i(slot_i), .bus_sel(bus_sel),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rd_latch_i(rd_latch_i), .wp_i(wp_i),
        .phase_o(phase_o), .motor_o(motor_o), .drive2_o(drive2_o),
        .drv_en_o(drv_en_o), .q6_o(q6_o), .q7_o(q7_o), .wr_byte_o(wr_byte_o)
    );

    // {offset, phase, motor, drive2, q6, q7} expected after the access
    localparam logic [11:0] VEC [NVEC] = '{
        {4'h1, 4'b0001, 4'b0000},
        {4'h3, 4'b0011, 4'b0000},
        {4'h0, 4'b0010, 4'b0000},
        {4'h5, 4'b0110, 4'b0000},
        {4'h7, 4'b1110, 4'b0000},
        {4'h2, 4'b1100, 4'b0000},
        {4'h9, 4'b1100, 4'b1000},
        {4'hB, 4'b1100, 4'b1100},
        {4'hD, 4'b1100, 4'b1110},
        {4'hF, 4'b1100, 4'b1111},
        {4'hC, 4'b1100, 4'b1101},
        {4'hA, 4'b1100, 4'b1001},
        {4'h8, 4'b1100, 4'b0001},
        {4'hE, 4'b1100, 4'b0000},
        {4'h6, 4'b0100, 4'b0000},
        {4'h4, 4'b0000, 4'b0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input logic we, input logic [7:0] wd,
                          output logic [7:0] rd);
        @(negedge clk);
        bus_sel = 1; bus_addr = a; bus_we = we; bus_wdata = wd;
        #(CLK_PERIOD/4);
        rd = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    function automatic logic [7:0] st();
        return {phase_o, motor_o, drive2_o, q6_o, q7_o};
    endfunction

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [15:0] w6;
        rst = 1; slot_i = 3'd6; bus_sel = 0; bus_addr = 0; bus_we = 0;
        bus_wdata = 0; rd_latch_i = 8'hA5; wp_i = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        check("R9 state", st(), 8'h00);
        check("R9 wr_byte", wr_byte_o, 8'h00);
        w6 = 16'hC0E0;

        // R2 R3 R4 R5 vector walk
        for (int i = 0; i < NVEC; i++) begin
            access(w6 | 16'(VEC[i][11:8]), 1'b0, 8'h00, rd);
            check("R2/R3/R4/R5 walk", st(), VEC[i][7:0]);
            check("R4 drv_en", drv_en_o, {motor_o & drive2_o, motor_o & ~drive2_o});
        end

        // R1 slot 0 never responds (window of slot 0 is C080)
        slot_i = 3'd0;
        access(16'hC089, 1'b0, 8'h00, rd);
        check("R1 slot0 ignored", st(), 8'h00);
        check("R10 slot0 rdata", rd, 8'h00);
        // R1 other slot's window ignored
        slot_i = 3'd6;
        access(16'hC0F9, 1'b0, 8'h00, rd);
        check("R1 foreign window ignored", st(), 8'h00);
        access(16'hD0E9, 1'b0, 8'h00, rd);
        check("R1 upper address mismatch ignored", st(), 8'h00);
        // R1 slot 1 window
        slot_i = 3'd1;
        access(16'hC099, 1'b0, 8'h00, rd);
        check("R3 slot1 motor on", motor_o, 1'b1);
        check("R4 slot1 drive1 powered", drv_en_o, 2'b01);

        // R6 read mode returns data latch
        access(16'hC090, 1'b0, 8'h00, rd);
        check("R6 read data", rd, 8'hA5);
        // R7 sense mode
        access(16'hC09D, 1'b0, 8'h00, rd);   // set Q6
        access(16'hC090, 1'b0, 8'h00, rd);
        check("R7 sense wp=1", rd, 8'h80);
        wp_i = 0;
        access(16'hC090, 1'b0, 8'h00, rd);
        check("R7 sense wp=0", rd, 8'h00);

        // R8 write with Q6=1 but Q7=0: no load
        access(16'hC09D, 1'b1, 8'h33, rd);
        check("R8 no load without Q7", wr_byte_o, 8'h00);
        // set Q7 -> load mode; rdata zero with Q7 high (R10)
        access(16'hC09F, 1'b0, 8'h00, rd);
        access(16'hC09D, 1'b1, 8'h5A, rd);
        check("R8 load", wr_byte_o, 8'h5A);
        check("R10 rdata with Q7", rd, 8'h00);
        // R8 read access in load mode does not load
        access(16'hC09D, 1'b0, 8'hC3, rd);
        check("R8 read no load", wr_byte_o, 8'h5A);
        // R8 write leaving Q6=0 does not load
        access(16'hC09C, 1'b1, 8'h77, rd);
        check("R8 write clearing Q6 no load", wr_byte_o, 8'h5A);
        // R1 miss write does not load
        access(16'hC09D, 1'b0, 8'h00, rd);
        slot_i = 3'd2;
        access(16'hC09D, 1'b1, 8'h11, rd);
        check("R1 miss write ignored", wr_byte_o, 8'h5A);
        // R10 no access -> rdata 0
        #1;
        check("R10 idle rdata", bus_rdata, 8'h00);

        // R9 reset again from busy state
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R9 state after reset", st(), 8'h00);
        check("R9 wr_byte after reset", wr_byte_o, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule